// File: doc/BRIEF.md
# Hierarchical Sticky Fault Status Aggregator

This block gathers fault conditions from several voltage-monitor channels and from control, self-test and internal-health sources, and latches each one into a sticky status bit. The bits live in seven leaf registers. Two read-only summary registers sit above them: a monitor summary with one bit per voltage leaf, and a global source register with one bit per branch. An active-low interrupt output is driven low while any leaf bit is set.

Software reads the registers through a plain byte-addressed port and clears a leaf bit by writing 1 to it. For faults that describe a lasting condition, such as a supply sitting outside its window or an overheated die, the clear only takes effect once the condition has gone away. For faults that describe a single event, such as a checksum mismatch or a finished self-test, the clear always takes effect. Per-bit enable inputs decide whether a fault may set its bit. Two bits ignore their enable: the interrupt-pin fault and the configuration double-error fault.

Top module: `fault_status_tree`

## Requirements
- R1: After reset every register reads 00h and `irq_n` is 1.
- R2: An enabled fault that is present at a clock edge sets its leaf bit at that edge. The bit stays set after the fault goes away, until software clears it.
- R3: A condition-type bit (all voltage-leaf bits, control bit 2 thermal, control bit 3 interrupt pin, vendor bits 6..0) stays set when 1 is written to it while its raw condition is still present.
- R4: A condition-type bit clears at the edge where 1 is written to it while its raw condition is absent.
- R5: An event-type bit (control bit 4 checksum, control bit 0 packet check, test bits 3..0) clears at the edge where 1 is written to it, whether or not its raw input is still high.
- R6: A fault whose enable input is 0 does not set its bit.
- R7: Control bit 3 and test bit 2 set whenever their raw input is high, whatever their enable input is.
- R8: If a bit sets and is written with 1 at the same edge, the bit ends up set.
- R9: The monitor summary at 11h reads bit0 = OR of leaf 12h, bit1 = OR of 14h, bit2 = OR of 16h and bit3 = OR of 18h. Bits 7..4 read 0.
- R10: The global register at 10h reads bit0 = OR of 11h, bit1 = OR of 22h, bit2 = OR of 23h and bit7 = OR of 24h. Bits 6..3 read 0.
- R11: Writes to 10h and 11h have no effect. Reserved leaf bits always read 0: bits 0 and 7..4 of the voltage leaves, bits 7..5 and 1 of 22h, bits 7..4 of 23h, and bit 7 of 24h.
- R12: `irq_n` is 0 exactly when the global register is nonzero.
- R13: The leaves live at 12h, 14h and 16h (fast under-voltage, slow under-voltage, fast over-voltage), at 18h (slow over-voltage), and at 22h, 23h and 24h (control, test, vendor). Channel k of a voltage input maps to leaf bit k+1. Any other address reads 00h, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Byte address for read and write |
| reg_wdata | input | 8 | Write data; a 1 bit requests a clear |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| uvf_raw | input | 3 | Fast under-voltage condition per channel |
| uvf_en | input | 3 | Enables for `uvf_raw` |
| uvs_raw | input | 3 | Slow under-voltage condition per channel |
| uvs_en | input | 3 | Enables for `uvs_raw` |
| ovf_raw | input | 3 | Fast over-voltage condition per channel |
| ovf_en | input | 3 | Enables for `ovf_raw` |
| ovs_raw | input | 3 | Slow over-voltage condition per channel |
| ovs_en | input | 3 | Enables for `ovs_raw` |
| ctl_raw | input | 5 | Control faults, laid out as leaf 22h bits 4..0 |
| ctl_en | input | 5 | Enables for `ctl_raw`; bit 3 is ignored |
| tst_raw | input | 4 | Self-test and configuration faults, laid out as leaf 23h bits 3..0 |
| tst_en | input | 4 | Enables for `tst_raw`; bit 2 is ignored |
| vnd_raw | input | 7 | Internal health conditions, laid out as leaf 24h bits 6..0 |
| vnd_en | input | 7 | Enables for `vnd_raw` |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The leaf assertions take for granted that a write strobe lasts one cycle, and that raw and enable inputs are settled before the clock edge that samples them. The bench therefore drives every input, strobe included, on the falling edge and drops the strobe on the next falling edge. The clear-blocking properties also rely on a condition-type input staying high for as long as its condition lasts. The stimulus holds such an input for the whole step in which the blocked clear is tried. Event inputs are raised for single steps, so the test of an always-effective clear keeps the raw line high but its enable low.

// File: rtl/fault_tree_pkg.sv
package fault_tree_pkg;
   localparam int NUM_LEAF = 7;

   typedef enum logic [2:0] {
      LF_UVF = 3'd0,
      LF_UVS = 3'd1,
      LF_OVF = 3'd2,
      LF_OVS = 3'd3,
      LF_CTL = 3'd4,
      LF_TST = 3'd5,
      LF_VND = 3'd6
   } leaf_e;

   localparam logic [7:0] GLB_ADDR = 8'h10;
   localparam logic [7:0] MON_ADDR = 8'h11;

   function automatic logic [7:0] leaf_addr(input int idx);
      case (idx)
         0:       return 8'h12;
         1:       return 8'h14;
         2:       return 8'h16;
         3:       return 8'h18;
         4:       return 8'h22;
         5:       return 8'h23;
         default: return 8'h24;
      endcase
   endfunction
endpackage

// File: rtl/fault_leaf_reg.sv
module fault_leaf_reg #(
   parameter int              DATA_W     = 8,
   parameter logic [DATA_W-1:0] IMPL_MASK  = '0,
   parameter logic [DATA_W-1:0] EVENT_MASK = '0,
   parameter logic [DATA_W-1:0] FORCE_MASK = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] raw_i,
   input  logic [DATA_W-1:0] en_i,
   input  logic              wr_hit_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] q_o
);
   if ((EVENT_MASK & ~IMPL_MASK) != '0) begin : g_chk_event
      $error("fault_leaf_reg: EVENT_MASK names unimplemented bits");
   end
   if ((FORCE_MASK & ~IMPL_MASK) != '0) begin : g_chk_force
      $error("fault_leaf_reg: FORCE_MASK names unimplemented bits");
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (IMPL_MASK[b]) begin : g_impl
         logic armed;
         logic set_now;
         logic clr_ok;
         logic clr_now;
         logic bit_q;

         if (FORCE_MASK[b]) begin : g_force
            assign armed = 1'b1;
         end else begin : g_gated
            assign armed = en_i[b];
         end

         if (EVENT_MASK[b]) begin : g_event
            assign clr_ok = 1'b1;
         end else begin : g_cond
            assign clr_ok = ~raw_i[b];
         end

         assign set_now = raw_i[b] & armed;
         assign clr_now = wr_hit_i & wdata_i[b] & clr_ok;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       bit_q <= 1'b0;
            else if (set_now) bit_q <= 1'b1;
            else if (clr_now) bit_q <= 1'b0;
         end
         assign q_o[b] = bit_q;

         p_enabled_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
            raw_i[b] && (en_i[b] || FORCE_MASK[b]) |=> bit_q);
         p_sticky_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            bit_q && !(wr_hit_i && wdata_i[b]) |=> bit_q);
         p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !bit_q && !(raw_i[b] && (en_i[b] || FORCE_MASK[b])) |=> !bit_q);
         p_set_beats_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
            raw_i[b] && (en_i[b] || FORCE_MASK[b]) && wr_hit_i && wdata_i[b] |=> bit_q);

         if (EVENT_MASK[b]) begin : g_evt_chk
            p_event_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
               wr_hit_i && wdata_i[b] && !(raw_i[b] && (en_i[b] || FORCE_MASK[b]))
               |=> !bit_q);
         end else begin : g_cond_chk
            p_cond_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
               bit_q && raw_i[b] |=> bit_q);
            p_cond_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
               wr_hit_i && wdata_i[b] && !raw_i[b] |=> !bit_q);
         end
      end else begin : g_rsvd
         assign q_o[b] = 1'b0;
      end
   end
endmodule

// File: rtl/fault_summary.sv
module fault_summary
   import fault_tree_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [NUM_LEAF-1:0][DATA_W-1:0] leaf_i,
   output logic [DATA_W-1:0]               mon_o,
   output logic [DATA_W-1:0]               glb_o,
   output logic                            irq_n_o
);
   localparam int NUM_MON = 4;

   if (DATA_W < 8) begin : g_chk_w
      $error("fault_summary: DATA_W must be at least 8");
   end

   always_comb begin
      mon_o = '0;
      for (int k = 0; k < NUM_MON; k++) mon_o[k] = |leaf_i[k];
   end

   always_comb begin
      glb_o    = '0;
      glb_o[0] = |mon_o;
      glb_o[1] = |leaf_i[LF_CTL];
      glb_o[2] = |leaf_i[LF_TST];
      glb_o[7] = |leaf_i[LF_VND];
   end

   assign irq_n_o = ~|glb_o;

   always_comb begin
      p_irq_level_r12: assert (irq_n_o == (leaf_i == '0));
   end
endmodule

// File: rtl/fault_regmap.sv
module fault_regmap
   import fault_tree_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [ADDR_W-1:0]               addr_i,
   input  logic                            wr_i,
   input  logic [NUM_LEAF-1:0][DATA_W-1:0] leaf_i,
   input  logic [DATA_W-1:0]               mon_i,
   input  logic [DATA_W-1:0]               glb_i,
   output logic [NUM_LEAF-1:0]             hit_o,
   output logic [DATA_W-1:0]               rdata_o
);
   if (ADDR_W < 8) begin : g_chk_a
      $error("fault_regmap: ADDR_W must be at least 8");
   end

   for (genvar k = 0; k < NUM_LEAF; k++) begin : g_hit
      assign hit_o[k] = wr_i && (addr_i == ADDR_W'(leaf_addr(k)));
   end

   always_comb begin
      rdata_o = '0;
      for (int k = 0; k < NUM_LEAF; k++) begin
         if (addr_i == ADDR_W'(leaf_addr(k))) rdata_o = leaf_i[k];
      end
      if (addr_i == ADDR_W'(MON_ADDR)) rdata_o = mon_i;
      if (addr_i == ADDR_W'(GLB_ADDR)) rdata_o = glb_i;
   end

   p_single_hit_r13: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_o));
   p_hit_needs_wr_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |-> hit_o == '0);
endmodule

// File: rtl/fault_status_tree.sv
module fault_status_tree
   import fault_tree_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int NUM_CH = 3,
   parameter int CH_LSB = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_wr,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NUM_CH-1:0] uvf_raw,
   input  logic [NUM_CH-1:0] uvf_en,
   input  logic [NUM_CH-1:0] uvs_raw,
   input  logic [NUM_CH-1:0] uvs_en,
   input  logic [NUM_CH-1:0] ovf_raw,
   input  logic [NUM_CH-1:0] ovf_en,
   input  logic [NUM_CH-1:0] ovs_raw,
   input  logic [NUM_CH-1:0] ovs_en,
   input  logic [4:0]        ctl_raw,
   input  logic [4:0]        ctl_en,
   input  logic [3:0]        tst_raw,
   input  logic [3:0]        tst_en,
   input  logic [6:0]        vnd_raw,
   input  logic [6:0]        vnd_en,
   output logic              irq_n
);
   localparam logic [DATA_W-1:0] CH_MASK   = DATA_W'(((1 << NUM_CH) - 1) << CH_LSB);
   localparam logic [DATA_W-1:0] CTL_IMPL  = DATA_W'(8'h1D);
   localparam logic [DATA_W-1:0] CTL_EVENT = DATA_W'(8'h11);
   localparam logic [DATA_W-1:0] CTL_FORCE = DATA_W'(8'h08);
   localparam logic [DATA_W-1:0] TST_IMPL  = DATA_W'(8'h0F);
   localparam logic [DATA_W-1:0] TST_EVENT = DATA_W'(8'h0F);
   localparam logic [DATA_W-1:0] TST_FORCE = DATA_W'(8'h04);
   localparam logic [DATA_W-1:0] VND_IMPL  = DATA_W'(8'h7F);

   if (DATA_W < 8) begin : g_chk_w
      $error("fault_status_tree: DATA_W must be at least 8");
   end
   if (NUM_CH < 1 || CH_LSB + NUM_CH > DATA_W) begin : g_chk_ch
      $error("fault_status_tree: channel field does not fit the data width");
   end

   logic [NUM_LEAF-1:0][DATA_W-1:0] leaf_raw;
   logic [NUM_LEAF-1:0][DATA_W-1:0] leaf_en;
   logic [NUM_LEAF-1:0][DATA_W-1:0] leaf_q;
   logic [NUM_LEAF-1:0]             leaf_hit;
   logic [DATA_W-1:0]               mon_sum;
   logic [DATA_W-1:0]               glb_sum;

   always_comb begin
      leaf_raw[LF_UVF] = DATA_W'(uvf_raw) << CH_LSB;
      leaf_en [LF_UVF] = DATA_W'(uvf_en)  << CH_LSB;
      leaf_raw[LF_UVS] = DATA_W'(uvs_raw) << CH_LSB;
      leaf_en [LF_UVS] = DATA_W'(uvs_en)  << CH_LSB;
      leaf_raw[LF_OVF] = DATA_W'(ovf_raw) << CH_LSB;
      leaf_en [LF_OVF] = DATA_W'(ovf_en)  << CH_LSB;
      leaf_raw[LF_OVS] = DATA_W'(ovs_raw) << CH_LSB;
      leaf_en [LF_OVS] = DATA_W'(ovs_en)  << CH_LSB;
      leaf_raw[LF_CTL] = DATA_W'(ctl_raw);
      leaf_en [LF_CTL] = DATA_W'(ctl_en);
      leaf_raw[LF_TST] = DATA_W'(tst_raw);
      leaf_en [LF_TST] = DATA_W'(tst_en);
      leaf_raw[LF_VND] = DATA_W'(vnd_raw);
      leaf_en [LF_VND] = DATA_W'(vnd_en);
   end

   for (genvar k = 0; k < NUM_LEAF; k++) begin : g_leaf
      localparam logic [DATA_W-1:0] IMPL  = (k < 4) ? CH_MASK :
                                            (k == 4) ? CTL_IMPL :
                                            (k == 5) ? TST_IMPL : VND_IMPL;
      localparam logic [DATA_W-1:0] EVENT = (k == 4) ? CTL_EVENT :
                                            (k == 5) ? TST_EVENT : '0;
      localparam logic [DATA_W-1:0] FORCE = (k == 4) ? CTL_FORCE :
                                            (k == 5) ? TST_FORCE : '0;
      fault_leaf_reg #(
         .DATA_W    (DATA_W),
         .IMPL_MASK (IMPL),
         .EVENT_MASK(EVENT),
         .FORCE_MASK(FORCE)
      ) i_leaf (
         .clk     (clk),
         .rst_n   (rst_n),
         .raw_i   (leaf_raw[k]),
         .en_i    (leaf_en[k]),
         .wr_hit_i(leaf_hit[k]),
         .wdata_i (reg_wdata),
         .q_o     (leaf_q[k])
      );
   end

   fault_summary #(.DATA_W(DATA_W)) i_summary (
      .leaf_i (leaf_q),
      .mon_o  (mon_sum),
      .glb_o  (glb_sum),
      .irq_n_o(irq_n)
   );

   fault_regmap #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regmap (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr_i (reg_addr),
      .wr_i   (reg_wr),
      .leaf_i (leaf_q),
      .mon_i  (mon_sum),
      .glb_i  (glb_sum),
      .hit_o  (leaf_hit),
      .rdata_o(reg_rdata)
   );

   p_irq_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n && !reg_wr |=> !irq_n);
   p_quiet_stays_r1: assert property (@(posedge clk) disable iff (!rst_n)
      irq_n && leaf_raw == '0 |=> irq_n);
endmodule

// File: tb/test_fault_status_tree.sv
module test_fault_status_tree;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] reg_addr = 8'h00;
   logic [7:0] reg_wdata = 8'h00;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_rdata;
   logic [2:0] uvf_raw = '0, uvf_en = '0, uvs_raw = '0, uvs_en = '0;
   logic [2:0] ovf_raw = '0, ovf_en = '0, ovs_raw = '0, ovs_en = '0;
   logic [4:0] ctl_raw = '0, ctl_en = '0;
   logic [3:0] tst_raw = '0, tst_en = '0;
   logic [6:0] vnd_raw = '0, vnd_en = '0;
   logic       irq_n;
   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   fault_status_tree i_fault_status_tree (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_wr(reg_wr), .reg_rdata(reg_rdata),
      .uvf_raw(uvf_raw), .uvf_en(uvf_en), .uvs_raw(uvs_raw), .uvs_en(uvs_en),
      .ovf_raw(ovf_raw), .ovf_en(ovf_en), .ovs_raw(ovs_raw), .ovs_en(ovs_en),
      .ctl_raw(ctl_raw), .ctl_en(ctl_en), .tst_raw(tst_raw), .tst_en(tst_en),
      .vnd_raw(vnd_raw), .vnd_en(vnd_en), .irq_n(irq_n)
   );

   // row: uvf_raw(3) uvf_en(3) write mask(8, 0 = no write) leaf 12h(8) summary 11h(8)
   localparam logic [29:0] VEC [0:7] = '{
      {3'b001, 3'b111, 8'h00, 8'h02, 8'h01},  // R2 enabled set of channel 0
      {3'b000, 3'b111, 8'h00, 8'h02, 8'h01},  // R2 sticky after recovery
      {3'b010, 3'b000, 8'h00, 8'h02, 8'h01},  // R6 disabled channel 1 stays clear
      {3'b001, 3'b000, 8'h02, 8'h02, 8'h01},  // R3 clear blocked while condition present
      {3'b000, 3'b000, 8'h02, 8'h00, 8'h00},  // R4 clear once condition gone
      {3'b110, 3'b110, 8'h00, 8'h0C, 8'h01},  // R2 R13 channels 1 and 2 at bits 2 and 3
      {3'b000, 3'b000, 8'hFF, 8'h00, 8'h00},  // R11 reserved bits stay 0
      {3'b100, 3'b100, 8'h08, 8'h08, 8'h01}   // R8 set wins over clear
   };

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
      reg_addr = a;
      #1;
      chk(tag, reg_rdata, exp);
   endtask

   // one cycle: optional write, then back on the falling edge
   task automatic cyc(input logic [7:0] a, input logic [7:0] d, input logic w);
      reg_addr = a; reg_wdata = d; reg_wr = w;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   initial begin
      #(20 * 5000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rd("R1 global", 8'h10, 8'h00);
      rd("R1 ctl", 8'h22, 8'h00);
      chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         uvf_raw = VEC[i][29:27];
         uvf_en  = VEC[i][26:24];
         cyc(8'h12, VEC[i][23:16], VEC[i][23:16] != 8'h00);
         rd($sformatf("R2/R3/R4/R8 vec%0d leaf", i), 8'h12, VEC[i][15:8]);
         rd($sformatf("R9 vec%0d summary", i), 8'h11, VEC[i][7:0]);
      end
      uvf_raw = '0; uvf_en = '0;
      cyc(8'h12, 8'h08, 1'b1);
      rd("R4 final clear", 8'h12, 8'h00);

      // event vs condition clears
      ctl_raw = 5'b00001; ctl_en = 5'b00001;
      cyc(8'h00, 8'h00, 1'b0);
      rd("R2 packet-check set", 8'h22, 8'h01);
      ctl_raw = 5'b00101; ctl_en = 5'b00100;
      cyc(8'h00, 8'h00, 1'b0);
      rd("R2 thermal set", 8'h22, 8'h05);
      ctl_en = 5'b00000;
      cyc(8'h22, 8'h05, 1'b1);
      rd("R5 R3 event clears thermal held", 8'h22, 8'h04);
      ctl_raw = '0;
      cyc(8'h22, 8'h04, 1'b1);
      rd("R4 thermal cleared", 8'h22, 8'h00);

      // always-enabled bits
      ctl_raw = 5'b01000; tst_raw = 4'b0100;
      cyc(8'h00, 8'h00, 1'b0);
      ctl_raw = '0; tst_raw = '0;
      rd("R7 pin fault", 8'h22, 8'h08);
      rd("R7 double error", 8'h23, 8'h04);
      rd("R10 global ctl+tst", 8'h10, 8'h06);
      chk("R12 irq_n low", {7'd0, irq_n}, 8'h00);
      cyc(8'h10, 8'hFF, 1'b1);
      rd("R11 global write ignored", 8'h10, 8'h06);
      cyc(8'h11, 8'hFF, 1'b1);
      cyc(8'h13, 8'hFF, 1'b1);
      rd("R13 unmapped reads 0", 8'h13, 8'h00);
      rd("R11 leaves unchanged", 8'h22, 8'h08);

      vnd_raw = 7'h40; vnd_en = 7'h40;
      cyc(8'h00, 8'h00, 1'b0);
      vnd_raw = '0;
      rd("R13 vendor leaf", 8'h24, 8'h40);
      rd("R10 global vendor", 8'h10, 8'h86);

      ovs_raw = 3'b001; ovs_en = 3'b001;
      cyc(8'h00, 8'h00, 1'b0);
      ovs_raw = '0;
      rd("R13 slow over-voltage leaf", 8'h18, 8'h02);
      rd("R9 summary bit3", 8'h11, 8'h08);
      rd("R10 global all", 8'h10, 8'h87);

      cyc(8'h22, 8'hFF, 1'b1);
      cyc(8'h23, 8'hFF, 1'b1);
      cyc(8'h24, 8'hFF, 1'b1);
      cyc(8'h18, 8'hFF, 1'b1);
      rd("R5 test leaf cleared", 8'h23, 8'h00);
      rd("R10 global empty", 8'h10, 8'h00);
      chk("R12 irq_n high", {7'd0, irq_n}, 8'h01);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule